// File: doc/BRIEF.md
# Two-Way Set-Associative Cache Controller with Line Locking

This block controls a 16 KB cache built as two ways of 256 sets, each set holding 32-byte lines of eight 32-bit words. A request presents the low, untranslated address bits together with an operation code and a write-policy attribute. The set is chosen from those virtual bits. The physical tag arrives one cycle later, after translation elsewhere, and the lookup compares it against both ways. The controller keeps the tag, valid, dirty and lock state of every line, and one replacement bit per set. It also keeps the line data, so a hit is answered without any memory traffic.

On a miss the controller chooses a victim way. The least recently used way is the default choice. A locked line is never chosen, and when both lines of a set are locked the request bypasses the cache. A dirty victim is written out word by word before a one-beat line-read request fetches the new line. Stores follow the attribute that comes with them. A write-through store updates the line and also writes the word to memory. A write-back store only marks the line dirty. Lines are locked and unlocked through two load-like operation codes.

Top module: `vipt_cache2w`

## Requirements
- R1: After reset `req_ready` is 1, `resp_valid` and `mem_req` are 0, and every line is invalid, so the first access to any set misses.
- R2: `req_vaddr[12:5]` selects the set and `req_vaddr[4:2]` the word. The tag compared is `pa_tag` as driven in the cycle after the request is accepted; its value in the acceptance cycle is ignored.
- R3: A load hit raises `resp_valid` for one cycle, two cycles after the request is driven in an accepting cycle, with the addressed word and no memory beat.
- R4: Each set's replacement choice points at the way not used by the latest hit or fill in that set, and an unlocked miss replaces that way.
- R5: A valid dirty victim is written out as eight write beats at ascending word addresses, using the victim's tag, before the line read is requested.
- R6: A line fill is one beat with `mem_line`=1, `mem_we`=0 and the line's base address, followed by eight `mem_rvalid` words in ascending order. A load miss returns the requested word from that fill.
- R7: A store with `req_wt`=0 that hits updates the line and sets its dirty bit without any memory beat. A later load returns the stored value.
- R8: A store with `req_wt`=1 updates the line, whether it hit or was filled, and issues one single-word memory write of that word. The line stays clean.
- R9: `req_op` encodes 0 = load, 1 = store, 2 = load and lock, 3 = load and unlock. Op 2 sets the lock bit of the line it hits or fills. Op 3 clears the lock bit of the line it hits.
- R10: A locked line is never replaced. If one way of a set is locked, every miss in that set replaces the other way.
- R11: When both ways of a set are locked, a miss allocates nothing. A load issues a single-word read (`mem_line`=0) and returns its data. A store issues a single-word write. A repeated access to the same address misses again.
- R12: A memory beat completes only when `mem_req` and `mem_ready` are both high at a clock edge. While `mem_ready` is low, the request, direction and address are held.
- R13: `resp_valid` is a single-cycle pulse, one per accepted request. Requests are accepted only while `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request |
| req_ready | output | 1 | Controller idle, request accepted this cycle |
| req_op | input | 2 | 0 load, 1 store, 2 load and lock, 3 load and unlock |
| req_wt | input | 1 | Store policy: 1 write-through, 0 write-back |
| req_vaddr | input | 11 | Virtual word address bits [12:2] |
| req_wdata | input | 32 | Store data |
| pa_tag | input | 19 | Physical address bits [31:13], valid the cycle after acceptance |
| resp_valid | output | 1 | Access complete |
| resp_rdata | output | 32 | Load data (store data echoed for stores) |
| mem_req | output | 1 | Memory beat request |
| mem_ready | input | 1 | Memory accepts the beat |
| mem_we | output | 1 | Beat is a word write |
| mem_line | output | 1 | Beat requests an eight-word line read |
| mem_addr | output | 32 | Byte address of the beat |
| mem_wdata | output | 32 | Write data |
| mem_rvalid | input | 1 | Read word returned |
| mem_rdata | input | 32 | Read data |

## Verification
A wrong replacement bit or a lost lock bit changes which tag is evicted. It shows up as an unexpected write-back beat, or as a missing or extra line read, at the first later miss in that set. A stale dirty bit appears as eight spurious write beats or as missing ones. A wrong tag or data word shows up as a wrong `resp_rdata` on the next access to that address. The bench predicts every memory beat and every response from a behavioural model and checks hit latency exactly, so any of these faults is reported within the access that exposes it.

// File: rtl/vipt_cache2w.sv
module vipt_cache2w #(
  parameter int SETS       = 256,
  parameter int LINE_WORDS = 8,
  parameter int PA_W       = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [1:0]          req_op,
  input  logic                req_wt,
  input  logic [12:2]         req_vaddr,
  input  logic [31:0]         req_wdata,
  input  logic [18:0]         pa_tag,
  output logic                resp_valid,
  output logic [31:0]         resp_rdata,
  output logic                mem_req,
  input  logic                mem_ready,
  output logic                mem_we,
  output logic                mem_line,
  output logic [31:0]         mem_addr,
  output logic [31:0]         mem_wdata,
  input  logic                mem_rvalid,
  input  logic [31:0]         mem_rdata
);
  localparam int IDX_W = $clog2(SETS);
  localparam int WRD_W = $clog2(LINE_WORDS);
  localparam int OFF_W = WRD_W + 2;
  localparam int VA_W  = IDX_W + OFF_W;
  localparam int TAG_W = PA_W - VA_W;
  localparam int DEPTH = SETS * LINE_WORDS;
  localparam logic [WRD_W-1:0] LAST = WRD_W'(LINE_WORDS - 1);

  typedef enum logic [2:0] {S_IDLE, S_LOOK, S_WB, S_FREQ, S_FILL, S_WT, S_BREQ, S_BDATA} st_t;
  st_t st;

  logic [IDX_W-1:0] idx;
  logic [WRD_W-1:0] wrd, cnt;
  logic [1:0]       op;
  logic             wt, vic;
  logic [31:0]      wd, rdata_q;
  logic [TAG_W-1:0] ptag;

  logic [SETS-1:0]  vld [2];
  logic [SETS-1:0]  drt [2];
  logic [SETS-1:0]  lck [2];
  logic [SETS-1:0]  lru;
  logic [TAG_W-1:0] tags [2][SETS];
  logic [31:0]      data [2][DEPTH];

  wire is_st   = (op == 2'd1);
  wire hit0    = vld[0][idx] && (tags[0][idx] == pa_tag);
  wire hit1    = vld[1][idx] && (tags[1][idx] == pa_tag);
  wire hit     = hit0 | hit1;
  wire hway    = hit1;
  wire all_lck = lck[0][idx] & lck[1][idx];
  wire pick    = lck[0][idx] ? 1'b1 : (lck[1][idx] ? 1'b0 : lru[idx]);
  wire pick_wb = vld[pick][idx] & drt[pick][idx];
  wire last    = (cnt == LAST);

  assign req_ready  = (st == S_IDLE);
  assign resp_rdata = rdata_q;
  assign mem_req    = (st == S_WB) || (st == S_FREQ) || (st == S_WT) || (st == S_BREQ);
  assign mem_we     = (st == S_WB) || (st == S_WT) || (st == S_BREQ && is_st);
  assign mem_line   = (st == S_FREQ);
  assign mem_wdata  = (st == S_WB) ? data[vic][{idx, cnt}] : wd;

  always_comb begin
    case (st)
      S_WB:    mem_addr = {tags[vic][idx], idx, cnt, 2'b00};
      S_FREQ:  mem_addr = {ptag, idx, {WRD_W{1'b0}}, 2'b00};
      default: mem_addr = {ptag, idx, wrd, 2'b00};
    endcase
  end

  logic             dwe, dway;
  logic [IDX_W+WRD_W-1:0] daddr;
  logic [31:0]      ddat;

  always_comb begin
    dwe   = 1'b0;
    dway  = vic;
    daddr = {idx, cnt};
    ddat  = mem_rdata;
    if (st == S_LOOK && hit && is_st) begin
      dwe   = 1'b1;
      dway  = hway;
      daddr = {idx, wrd};
      ddat  = wd;
    end else if (st == S_FILL && mem_rvalid) begin
      dwe  = 1'b1;
      ddat = (is_st && cnt == wrd) ? wd : mem_rdata;
    end
  end

  always_ff @(posedge clk) begin
    if (dwe) data[dway][daddr] <= ddat;
    if (st == S_FILL && mem_rvalid && last) tags[vic][idx] <= ptag;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      resp_valid <= 1'b0;
      vld[0] <= '0; vld[1] <= '0;
      drt[0] <= '0; drt[1] <= '0;
      lck[0] <= '0; lck[1] <= '0;
      lru    <= '0;
      cnt    <= '0;
      vic    <= 1'b0;
      idx    <= '0;
      wrd    <= '0;
      op     <= '0;
      wt     <= 1'b0;
      wd     <= '0;
      ptag   <= '0;
      rdata_q <= '0;
    end else begin
      resp_valid <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          idx <= req_vaddr[VA_W-1:OFF_W];
          wrd <= req_vaddr[OFF_W-1:2];
          op  <= req_op;
          wt  <= req_wt;
          wd  <= req_wdata;
          st  <= S_LOOK;
        end
        S_LOOK: begin
          ptag <= pa_tag;
          cnt  <= '0;
          if (hit) begin
            lru[idx] <= ~hway;
            if (op == 2'd2) lck[hway][idx] <= 1'b1;
            if (op == 2'd3) lck[hway][idx] <= 1'b0;
            if (is_st && !wt) drt[hway][idx] <= 1'b1;
            rdata_q <= is_st ? wd : data[hway][{idx, wrd}];
            if (is_st && wt) st <= S_WT;
            else begin
              st         <= S_IDLE;
              resp_valid <= 1'b1;
            end
          end else if (all_lck) begin
            st <= S_BREQ;
          end else begin
            vic <= pick;
            st  <= pick_wb ? S_WB : S_FREQ;
          end
        end
        S_WB: if (mem_ready) begin
          cnt <= cnt + 1'b1;
          if (last) st <= S_FREQ;
        end
        S_FREQ: if (mem_ready) st <= S_FILL;
        S_FILL: if (mem_rvalid) begin
          cnt <= cnt + 1'b1;
          if (cnt == wrd) rdata_q <= is_st ? wd : mem_rdata;
          if (last) begin
            vld[vic][idx] <= 1'b1;
            drt[vic][idx] <= is_st & ~wt;
            lck[vic][idx] <= (op == 2'd2);
            lru[idx]      <= ~vic;
            if (is_st && wt) st <= S_WT;
            else begin
              st         <= S_IDLE;
              resp_valid <= 1'b1;
            end
          end
        end
        S_WT: if (mem_ready) begin
          st         <= S_IDLE;
          resp_valid <= 1'b1;
        end
        S_BREQ: if (mem_ready) begin
          if (is_st) begin
            rdata_q    <= wd;
            resp_valid <= 1'b1;
            st         <= S_IDLE;
          end else st <= S_BDATA;
        end
        S_BDATA: if (mem_rvalid) begin
          rdata_q    <= mem_rdata;
          resp_valid <= 1'b1;
          st         <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_SINGLE_WAY_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_LOOK) |-> !(hit0 && hit1)); // R2
  AST_VICTIM_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_FILL) |-> !lck[vic][idx]); // R10
  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we))); // R12
  AST_RESP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |=> !resp_valid); // R13
  AST_RESP_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> req_ready); // R13
  AST_LINE_IS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_line) |-> $past(st == S_LOOK || st == S_WB)); // R5
endmodule

// File: tb/vipt_cache2w_test.sv
module vipt_cache2w_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_wt = 1'b0;
  logic [1:0] req_op = '0;
  logic [12:2] req_vaddr = '0;
  logic [31:0] req_wdata = '0;
  logic [18:0] pa_tag = '0;
  logic req_ready, resp_valid, mem_req, mem_we, mem_line;
  logic [31:0] resp_rdata, mem_addr, mem_wdata;
  logic mem_ready = 1'b0, mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;

  vipt_cache2w uut (.clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_wt(req_wt), .req_vaddr(req_vaddr), .req_wdata(req_wdata),
    .pa_tag(pa_tag), .resp_valid(resp_valid), .resp_rdata(resp_rdata), .mem_req(mem_req),
    .mem_ready(mem_ready), .mem_we(mem_we), .mem_line(mem_line), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata));

  always #10 clk = ~clk;

  int cyc = 0, tests = 0, fails = 0, acc = 0;

  bit [31:0] memm [bit [29:0]];
  bit        mv [2][256], md [2][256], mk [2][256];
  bit [18:0] mt [2][256];
  bit        ml [256];
  bit [31:0] mdat [2][256][8];

  bit        eb_we[$], eb_line[$];
  bit [29:0] eb_a[$];
  bit [31:0] eb_d[$];
  string     eb_tag[$];
  bit [31:0] er_d[$];
  string     er_tag[$];
  int        er_lat[$];
  bit [31:0] rq[$];

  task automatic chk(bit ok, string tg, string what, longint act, longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: got %0h expected %0h", tg, what, act, exp);
    end
  endtask

  function automatic bit [31:0] rd_mem(bit [29:0] a);
    if (memm.exists(a)) return memm[a];
    return {2'b0, a} * 32'h9E3779B1 ^ 32'h5A5A0000;
  endfunction

  function automatic bit [29:0] wa(bit [18:0] t, int ix, int w);
    return {t, 8'(ix), 3'(w)};
  endfunction

  function automatic void push_beat(bit we, bit line, bit [29:0] a, bit [31:0] d, string tg);
    eb_we.push_back(we); eb_line.push_back(line); eb_a.push_back(a);
    eb_d.push_back(d); eb_tag.push_back(tg);
  endfunction

  function automatic void model(bit [1:0] op, int ix, int w, bit [18:0] t, bit wt,
                                bit [31:0] wd, string tg);
    bit st = (op == 2'd1);
    int h = -1, v;
    bit [31:0] r;
    bit [29:0] a = wa(t, ix, w);
    for (int i = 0; i < 2; i++) if (mv[i][ix] && mt[i][ix] == t) h = i;
    if (h >= 0) begin
      ml[ix] = (h == 0);
      if (op == 2'd2) mk[h][ix] = 1'b1;
      if (op == 2'd3) mk[h][ix] = 1'b0;
      if (st) begin
        mdat[h][ix][w] = wd;
        if (wt) begin push_beat(1, 0, a, wd, "R8"); memm[a] = wd; end
        else md[h][ix] = 1'b1;
      end
      r = st ? wd : mdat[h][ix][w];
      er_d.push_back(r); er_tag.push_back(tg); er_lat.push_back((st && wt) ? -1 : 2);
    end else if (mk[0][ix] && mk[1][ix]) begin
      if (st) begin push_beat(1, 0, a, wd, "R11"); memm[a] = wd; r = wd; end
      else begin push_beat(0, 0, a, 0, "R11"); r = rd_mem(a); end
      er_d.push_back(r); er_tag.push_back(tg); er_lat.push_back(-1);
    end else begin
      v = mk[0][ix] ? 1 : (mk[1][ix] ? 0 : int'(ml[ix]));
      if (mv[v][ix] && md[v][ix])
        for (int i = 0; i < 8; i++) begin
          push_beat(1, 0, wa(mt[v][ix], ix, i), mdat[v][ix][i], "R5");
          memm[wa(mt[v][ix], ix, i)] = mdat[v][ix][i];
        end
      push_beat(0, 1, wa(t, ix, 0), 0, "R6");
      for (int i = 0; i < 8; i++) mdat[v][ix][i] = rd_mem(wa(t, ix, i));
      mv[v][ix] = 1'b1; mt[v][ix] = t; md[v][ix] = 1'b0; mk[v][ix] = (op == 2'd2);
      ml[ix] = (v == 0);
      if (st) begin
        mdat[v][ix][w] = wd;
        if (wt) begin push_beat(1, 0, a, wd, "R8"); memm[a] = wd; end
        else md[v][ix] = 1'b1;
      end
      r = st ? wd : mdat[v][ix][w];
      er_d.push_back(r); er_tag.push_back(tg); er_lat.push_back(-1);
    end
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      tests++; fails++;
      $display("FAIL R13 watchdog expired: got %0d expected %0d", cyc, 150000);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  always @(negedge clk) if (rst_n) begin
    if (resp_valid) begin
      if (er_d.size() == 0) chk(0, "R13", "unexpected response", resp_rdata, 0);
      else begin
        automatic bit [31:0] d = er_d.pop_front();
        automatic string tg = er_tag.pop_front();
        automatic int lat = er_lat.pop_front();
        chk(resp_rdata == d, tg, "response data", resp_rdata, d);
        if (lat >= 0) chk(cyc == acc + lat, tg, "hit latency R3", cyc - acc, lat);
      end
    end
    mem_rvalid = 1'b0;
    if (rq.size() > 0 && cyc % 4 != 2) begin
      mem_rvalid = 1'b1;
      mem_rdata  = rq.pop_front();
    end
    mem_ready = (cyc % 5 != 3);
    if (mem_req && mem_ready) begin
      // R12: a beat is counted once, at its ready handshake
      if (eb_a.size() == 0) chk(0, "R12", "unexpected memory beat", mem_addr, 0);
      else begin
        automatic bit we = eb_we.pop_front();
        automatic bit ln = eb_line.pop_front();
        automatic bit [29:0] a = eb_a.pop_front();
        automatic bit [31:0] d = eb_d.pop_front();
        automatic string tg = {eb_tag.pop_front(), " R12"};
        chk(mem_we == we, tg, "beat direction", mem_we, we);
        chk(mem_line == ln, tg, "beat line flag", mem_line, ln);
        chk(mem_addr[31:2] == a && mem_addr[1:0] == 2'b00, tg, "beat address", mem_addr, {a, 2'b00});
        if (we) chk(mem_wdata == d, tg, "beat write data", mem_wdata, d);
        else for (int i = 0; i < (ln ? 8 : 1); i++) rq.push_back(rd_mem(a + 30'(i)));
      end
    end
  end

  task automatic access(bit [1:0] op, int ix, int w, bit [18:0] t, bit wt, bit [31:0] wd,
                        string tg);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    model(op, ix, w, t, wt, wd, tg);
    acc       = cyc;
    req_valid = 1'b1;
    req_op    = op;
    req_wt    = wt;
    req_vaddr = {8'(ix), 3'(w)};
    req_wdata = wd;
    pa_tag    = ~t;
    @(negedge clk);
    req_valid = 1'b0;
    pa_tag    = t;
    while (er_d.size() != 0) @(negedge clk);
    chk(eb_a.size() == 0, tg, "beats left after response", eb_a.size(), 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1", "ready after reset", req_ready, 1);
    chk(resp_valid == 1'b0, "R1", "resp after reset", resp_valid, 0);
    chk(mem_req == 1'b0, "R1", "mem_req after reset", mem_req, 0);

    access(0, 5, 3, 19'h100, 0, 0, "R6");
    access(0, 5, 6, 19'h100, 0, 0, "R3");
    access(0, 5, 0, 19'h101, 0, 0, "R2");
    access(1, 5, 2, 19'h100, 0, 32'hCAFE0001, "R7");
    access(0, 5, 2, 19'h100, 0, 0, "R7");
    access(0, 5, 1, 19'h102, 0, 0, "R4");
    access(0, 5, 4, 19'h103, 0, 0, "R5");
    access(1, 5, 4, 19'h103, 1, 32'h12345678, "R8");
    access(0, 5, 4, 19'h103, 0, 0, "R8");
    access(1, 7, 7, 19'h020, 1, 32'hA5A5F00D, "R8");
    access(2, 9, 0, 19'h040, 0, 0, "R9");
    access(0, 9, 1, 19'h041, 0, 0, "R10");
    access(0, 9, 2, 19'h042, 0, 0, "R10");
    access(0, 9, 3, 19'h043, 0, 0, "R10");
    access(0, 9, 0, 19'h040, 0, 0, "R10");
    access(2, 9, 3, 19'h043, 0, 0, "R9");
    access(0, 9, 5, 19'h050, 0, 0, "R11");
    access(1, 9, 5, 19'h050, 0, 32'hBEEF0055, "R11");
    access(0, 9, 5, 19'h050, 0, 0, "R11");
    access(3, 9, 0, 19'h040, 0, 0, "R9");
    access(0, 9, 6, 19'h051, 0, 0, "R10");
    access(0, 9, 6, 19'h040, 0, 0, "R4");
    for (int n = 0; n < 400; n++)
      access(2'($urandom_range(0, 3)), ($urandom_range(0, 1) == 0) ? 1 : 2,
             $urandom_range(0, 7), 19'h300 + 19'($urandom_range(0, 3)),
             1'($urandom_range(0, 1)), $urandom, "R4");
    repeat (4) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule